// File: doc/BRIEF.md
# DQS Read-Delay Training Engine

This block calibrates the read-capture delay of every byte lane on a DDR data bus. For each lane chosen by a select mask it sweeps a 5-bit delay tap upward from zero. At each tap it reads a fixed eight-byte reference pattern back through a simple byte-read port and judges each byte. A byte is judged from its data and from the memory controller's sticky "masked read data" and "dummy read data" flags. The engine first looks for the lowest tap at which a whole scan is clean. It then keeps stepping until a scan fails. It programs the lane's tap to the middle of the clean window it found.

Before every byte read, the engine pulses the PHY read FIFO reset and the status-flag clear strobe. After a lane is centred it pulses the FIFO reset once more. The selected lanes are trained one at a time in ascending order. Each lane reports a 2-bit result code. A single-cycle done pulse marks the end of the whole run. The reference data must already be stored in memory before training starts.

Top module: `dqs_rd_train`

## Requirements
- R1: After reset every lane tap is 0 and every result code is 00. The first read issued for any lane during training is made with that lane's tap at 0.
- R2: Byte i (0..7) of lane k is read at address k + 4·i, with i taken in ascending order. The expected bytes are FE, 11, 33, 55, 77, 99, BB, DD.
- R3: Every read request is preceded by a one-cycle pulse on both the FIFO reset and the flag-clear strobe, issued after the previous request.
- R4: A byte fails if its data differs from the expected byte, or if either error flag is high in the cycle after the response. A correct byte that arrives with a flag set still fails.
- R5: In the first phase, any failing byte raises the tap by one and restarts the scan at byte 0. The first tap at which all eight bytes pass becomes the window start.
- R6: In the second phase, a clean scan raises the tap by one and rescans. The tap at which the first byte fails becomes the window end, and that byte ends the phase.
- R7: On success the lane tap becomes start + ((end − start) >> 1) and the lane's code becomes 00 (OK).
- R8: If a step is needed while the tap is already 31, training of that lane stops. Its code becomes 10 (error) and its tap stays at 31.
- R9: Lanes are trained in ascending index order, and only selected lanes are trained. A selected lane shows code 01 (running) from the start pulse until it finishes. Unselected lanes keep their tap and code. Lane k's tap is on tap bits [5k+4:5k] and its code on result bits [2k+1:2k].
- R10: Exactly one single-cycle done pulse follows the last selected lane. A start pulse is ignored while a run is in progress, and a start pulse with an empty mask is ignored.
- R11: A read request holds its valid and address stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a training run |
| lane_sel_i | input | NUM_LANES | Mask of lanes to train, sampled with start |
| tap_o | output | NUM_LANES*TAP_W | Delay tap for each lane |
| result_o | output | NUM_LANES*2 | Result code for each lane: 00 OK, 01 running, 10 error |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| phy_fifo_rst_o | output | 1 | PHY read FIFO reset pulse |
| rd_valid_o | output | 1 | Byte read request valid |
| rd_ready_i | input | 1 | Byte read request accepted |
| rd_addr_o | output | ADDR_W | Byte read address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 8 | Read response byte |
| st_masked_i | input | 1 | Sticky flag: read data masked |
| st_dummy_i | input | 1 | Sticky flag: dummy read data |
| st_clr_o | output | 1 | Clear strobe for the sticky flags |

## Verification
The data comparison and the flag check judge the same byte in the same cycle, so they can disagree. A byte can carry exactly the right value while a sticky error flag is raised beside it. The bench provokes this by returning correct data together with a dummy or masked flag at a chosen tap and byte inside the clean window. It judges the outcome from the final centred tap: the start tap must be pushed past the flagged tap, or the window must end early. The tap step at the top of the range is also exercised when it coincides with a clean scan, and this must give an error rather than a wrap to zero.

// File: rtl/dqs_train_pkg.sv
package dqs_train_pkg;

  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_BUSY = 2'b01,
    RES_ERR  = 2'b10
  } lane_res_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PREP   = 3'd1,
    ST_REQ    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_FLAG   = 3'd4,
    ST_FINISH = 3'd5,
    ST_NEXT   = 3'd6
  } trn_state_e;

  localparam int unsigned PAT_BYTES = 8;

  // expected byte i: FE first, then the nibble 2i-1 doubled (11, 33, ... DD)
  function automatic logic [7:0] pattern_byte(input logic [2:0] idx);
    logic [3:0] nib;
    nib = {idx, 1'b0} - 4'd1;
    return (idx == 3'd0) ? 8'hFE : {nib, nib};
  endfunction

  function automatic int unsigned window_centre(input int unsigned first_ok,
                                                input int unsigned first_bad);
    return first_ok + ((first_bad - first_ok) >> 1);
  endfunction

  function automatic int unsigned byte_addr(input int unsigned lane,
                                            input int unsigned idx,
                                            input int unsigned stride);
    return lane + stride * idx;
  endfunction

endpackage

// File: rtl/dqs_byte_judge.sv
module dqs_byte_judge import dqs_train_pkg::*; (
  input  logic [7:0] rd_byte,
  input  logic [2:0] byte_idx,
  input  logic       flag_masked,
  input  logic       flag_dummy,
  output logic       byte_ok
);
  logic data_match;
  logic flag_hit;

  assign data_match = (rd_byte == pattern_byte(byte_idx));
  assign flag_hit   = flag_masked | flag_dummy;
  // a raised flag overrides a matching byte (R4)
  assign byte_ok    = data_match & ~flag_hit;
endmodule

// File: rtl/dqs_lane_pick.sv
module dqs_lane_pick #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 2
) (
  input  logic [NUM_LANES-1:0] mask,
  input  logic [LANE_W-1:0]    base_lane,
  input  logic                 from_zero,
  output logic                 found,
  output logic [LANE_W-1:0]    next_lane
);
  // lowest selected lane above base (or from lane 0): ascending order (R9)
  always_comb begin
    found     = 1'b0;
    next_lane = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (mask[i] && (from_zero || (i > int'(base_lane)))) begin
        found     = 1'b1;
        next_lane = LANE_W'(i);
      end
    end
  end
endmodule

// File: rtl/dqs_tap_bank.sv
module dqs_tap_bank import dqs_train_pkg::*; #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 5,
  parameter int LANE_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tap_we,
  input  logic [LANE_W-1:0]            tap_lane,
  input  logic [TAP_W-1:0]             tap_val,
  input  logic                         res_we,
  input  logic [LANE_W-1:0]            res_lane,
  input  logic [1:0]                   res_val,
  input  logic                         busy_we,
  input  logic [NUM_LANES-1:0]         busy_mask,
  output logic [NUM_LANES*TAP_W-1:0]   taps_flat,
  output logic [NUM_LANES*2-1:0]       res_flat
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [TAP_W-1:0] tap_q;
    logic [1:0]       res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q <= '0;
        res_q <= RES_OK;
      end else begin
        if (tap_we && (tap_lane == LANE_W'(g))) tap_q <= tap_val;
        if (busy_we && busy_mask[g])            res_q <= RES_BUSY;
        else if (res_we && (res_lane == LANE_W'(g))) res_q <= res_val;
      end
    end

    assign taps_flat[g*TAP_W +: TAP_W] = tap_q;
    assign res_flat[g*2 +: 2]          = res_q;
  end
endmodule

// File: rtl/dqs_rd_train.sv
module dqs_rd_train import dqs_train_pkg::*; #(
  parameter int NUM_LANES   = 4,
  parameter int TAP_W       = 5,
  parameter int ADDR_W      = 8,
  parameter int LANE_STRIDE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [NUM_LANES-1:0]       lane_sel_i,
  output logic [NUM_LANES*TAP_W-1:0] tap_o,
  output logic [NUM_LANES*2-1:0]     result_o,
  output logic                       done_o,
  output logic                       phy_fifo_rst_o,
  output logic                       rd_valid_o,
  input  logic                       rd_ready_i,
  output logic [ADDR_W-1:0]          rd_addr_o,
  input  logic                       rsp_valid_i,
  input  logic [7:0]                 rsp_data_i,
  input  logic                       st_masked_i,
  input  logic                       st_dummy_i,
  output logic                       st_clr_o
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int IDX_W  = $clog2(PAT_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_BYTES - 1);
  localparam logic [TAP_W-1:0] TAP_MAX  = '1;

  trn_state_e           state_q;
  logic [LANE_W-1:0]    lane_q;
  logic [IDX_W-1:0]     idx_q;
  logic [TAP_W-1:0]     sweep_q;
  logic [TAP_W-1:0]     win_lo_q;
  logic [TAP_W-1:0]     win_hi_q;
  logic                 phase2_q;
  logic [7:0]           rsp_q;
  logic [NUM_LANES-1:0] sel_q;
  logic                 done_q;

  // named internal events
  logic byte_ok, need_step;
  logic ev_launch, ev_judge, ev_scan_done, ev_step, ev_sat_err;
  logic ev_found, ev_window_end, ev_centre, ev_lane_start, ev_all_done;
  logic                 pick_found;
  logic [LANE_W-1:0]    pick_lane;
  logic [TAP_W-1:0]     centre_val;
  logic [TAP_W-1:0]     active_tap;

  logic                 tap_we;
  logic [LANE_W-1:0]    tap_lane;
  logic [TAP_W-1:0]     tap_val;
  logic [1:0]           res_val;

  dqs_byte_judge u_judge (
    .rd_byte     (rsp_q),
    .byte_idx    (3'(idx_q)),
    .flag_masked (st_masked_i),
    .flag_dummy  (st_dummy_i),
    .byte_ok     (byte_ok)
  );

  dqs_lane_pick #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_pick (
    .mask      ((state_q == ST_IDLE) ? lane_sel_i : sel_q),
    .base_lane (lane_q),
    .from_zero (state_q == ST_IDLE),
    .found     (pick_found),
    .next_lane (pick_lane)
  );

  assign ev_launch     = (state_q == ST_IDLE) && start_i && (|lane_sel_i);
  assign ev_judge      = (state_q == ST_FLAG);
  assign ev_scan_done  = ev_judge && byte_ok && (idx_q == IDX_LAST);
  assign need_step     = ev_judge && (phase2_q ? ev_scan_done : !byte_ok);
  assign ev_sat_err    = need_step && (sweep_q == TAP_MAX);
  assign ev_step       = need_step && (sweep_q != TAP_MAX);
  assign ev_found      = !phase2_q && ev_scan_done;
  assign ev_window_end = phase2_q && ev_judge && !byte_ok;
  assign ev_centre     = (state_q == ST_FINISH);
  assign ev_lane_start = ev_launch || ((state_q == ST_NEXT) && pick_found);
  assign ev_all_done   = (state_q == ST_NEXT) && !pick_found;

  assign centre_val = TAP_W'(window_centre(32'(win_lo_q), 32'(win_hi_q)));

  assign tap_we   = ev_lane_start | ev_step | ev_centre;
  assign tap_lane = ev_lane_start ? pick_lane : lane_q;
  assign tap_val  = ev_centre ? centre_val :
                    ev_step   ? (sweep_q + TAP_W'(1)) : '0;
  assign res_val  = ev_centre ? RES_OK : RES_ERR;

  dqs_tap_bank #(.NUM_LANES(NUM_LANES), .TAP_W(TAP_W), .LANE_W(LANE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_we    (tap_we),
    .tap_lane  (tap_lane),
    .tap_val   (tap_val),
    .res_we    (ev_sat_err | ev_centre),
    .res_lane  (lane_q),
    .res_val   (res_val),
    .busy_we   (ev_launch),
    .busy_mask (lane_sel_i),
    .taps_flat (tap_o),
    .res_flat  (result_o)
  );

  assign active_tap = tap_o[lane_q*TAP_W +: TAP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lane_q   <= '0;
      idx_q    <= '0;
      sweep_q  <= '0;
      win_lo_q <= '0;
      win_hi_q <= '0;
      phase2_q <= 1'b0;
      rsp_q    <= '0;
      sel_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= ev_all_done;
      case (state_q)
        ST_IDLE: if (ev_launch) sel_q <= lane_sel_i;
        ST_PREP: state_q <= ST_REQ;
        ST_REQ:  if (rd_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          rsp_q   <= rsp_data_i;
          state_q <= ST_FLAG;
        end
        ST_FLAG: begin
          if (ev_sat_err) begin
            state_q <= ST_NEXT;
          end else if (ev_window_end) begin
            win_hi_q <= sweep_q;
            state_q  <= ST_FINISH;
          end else begin
            state_q <= ST_PREP;
            if (ev_step) begin
              sweep_q <= sweep_q + TAP_W'(1);
              idx_q   <= '0;
            end else if (ev_found) begin
              win_lo_q <= sweep_q;
              phase2_q <= 1'b1;
              idx_q    <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_FINISH: state_q <= ST_NEXT;
        ST_NEXT:   if (!pick_found) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
      if (ev_lane_start) begin
        lane_q   <= pick_lane;
        sweep_q  <= '0;
        idx_q    <= '0;
        phase2_q <= 1'b0;
        state_q  <= ST_PREP;
      end
    end
  end

  assign phy_fifo_rst_o = (state_q == ST_PREP) || (state_q == ST_FINISH);
  assign st_clr_o       = (state_q == ST_PREP);
  assign rd_valid_o     = (state_q == ST_REQ);
  assign rd_addr_o      = ADDR_W'(byte_addr(32'(lane_q), 32'(idx_q), LANE_STRIDE));
  assign done_o         = done_q;

  // ---------------- assertions ----------------
  assert_new_lane_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lane_start |=> (active_tap == '0));

  assert_clr_before_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(st_clr_o && phy_fifo_rst_o));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_step, ev_sat_err, ev_found, ev_window_end}));

  assert_tap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (active_tap == $past(sweep_q) + TAP_W'(1)));

  assert_centre_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_centre |=> (active_tap >= $past(win_lo_q)) && (active_tap < $past(win_hi_q)));

  assert_sat_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat_err |-> (active_tap == TAP_MAX));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

endmodule

// File: tb/sim_dqs_rd_train.sv
`timescale 1ns/1ps
module sim_dqs_rd_train;
  localparam int NL = 4;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NL-1:0] lane_sel_i = '0;
  logic [NL*TW-1:0] tap_o;
  logic [NL*2-1:0] result_o;
  logic done_o, phy_fifo_rst_o, rd_valid_o, st_clr_o;
  logic rd_ready_i, rsp_valid_i, st_masked_i, st_dummy_i;
  logic [7:0] rd_addr_o, rsp_data_i;

  always #2.5 clk = ~clk;

  dqs_rd_train u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_sel_i(lane_sel_i),
    .tap_o(tap_o), .result_o(result_o), .done_o(done_o),
    .phy_fifo_rst_o(phy_fifo_rst_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_addr_o(rd_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .st_masked_i(st_masked_i), .st_dummy_i(st_dummy_i), .st_clr_o(st_clr_o)
  );

  int checks = 0, errors = 0;
  logic [7:0] ref_tab [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};

  // memory model configuration
  int win_lo [NL], win_hi [NL], bad_idx [NL];
  int inj_kind = 0, inj_lane = 0, inj_tap = 0, inj_idx = 0;
  bit stall_en = 0;
  logic [NL-1:0] cur_sel = '0;

  // model bookkeeping
  int unsigned cyc = 0;
  bit pend = 0, pend_m = 0, pend_d = 0, clr_seen = 0, last_stall = 0;
  logic [7:0] pend_data = '0, last_addr = '0;
  int prev_lane = -1;
  int addr_err = 0, clr_err = 0, order_err = 0, first_err = 0, hold_err = 0;
  int req_cnt = 0, done_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lane_tap(input int l);
    return int'(tap_o[l*TW +: TW]);
  endfunction

  function automatic int lane_res(input int l);
    return int'(result_o[l*2 +: 2]);
  endfunction

  task automatic serve();
    int l, i, t;
    bit good;
    l = int'(rd_addr_o) % 4;
    i = int'(rd_addr_o) / 4;
    req_cnt++;
    if (i > 7 || l >= NL) begin addr_err++; i = 0; end         // R2
    if (!clr_seen) clr_err++;                                  // R3
    clr_seen = 0;
    t = lane_tap(l);
    if (l != prev_lane) begin
      if (l < prev_lane) order_err++;                          // R9
      if (t != 0) first_err++;                                 // R1
      prev_lane = l;
    end
    if (!cur_sel[l]) order_err++;
    good = (t >= win_lo[l]) && (t <= win_hi[l]);
    pend_data = (good || (bad_idx[l] >= 0 && i != bad_idx[l])) ? ref_tab[i] : (ref_tab[i] ^ 8'h04);
    pend_m = 0; pend_d = 0;
    if (inj_kind != 0 && l == inj_lane && t == inj_tap && i == inj_idx) begin
      pend_data = ref_tab[i];
      if (inj_kind == 1) pend_m = 1; else pend_d = 1;
    end
    pend = 1;
  endtask

  initial begin
    rd_ready_i = 0; rsp_valid_i = 0; rsp_data_i = '0; st_masked_i = 0; st_dummy_i = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (last_stall && !(rd_valid_o && rd_addr_o == last_addr)) hold_err++;   // R11
      rsp_valid_i = 0;
      if (st_clr_o) begin st_masked_i = 0; st_dummy_i = 0; clr_seen = 1; end
      if (pend) begin
        rsp_valid_i = 1; rsp_data_i = pend_data;
        if (pend_m) st_masked_i = 1;
        if (pend_d) st_dummy_i = 1;
        pend = 0;
      end
      rd_ready_i = !(stall_en && (cyc % 3 != 0));
      last_stall = rd_valid_o && !rd_ready_i;
      last_addr  = rd_addr_o;
      if (rd_valid_o && rd_ready_i) serve();
      if (done_o) done_cnt++;
    end
  end

  // expected outcome computed from the window rules
  function automatic bit tap_ok(input int l, input int t);
    return (t >= win_lo[l]) && (t <= win_hi[l]) &&
           !(inj_kind != 0 && l == inj_lane && t == inj_tap);
  endfunction

  task automatic verify_lane(input int l, input string req);
    int s, e, exp_code, exp_tap;
    s = -1; e = -1;
    for (int t = 0; t < 32; t++) begin
      if (s < 0) begin if (tap_ok(l, t)) s = t; end
      else if (e < 0 && !tap_ok(l, t)) e = t;
    end
    if (s < 0 || e < 0) begin exp_code = 2; exp_tap = 31; end
    else begin exp_code = 0; exp_tap = (s + e) / 2; end
    chk(lane_tap(l) == exp_tap, req, lane_tap(l), exp_tap);
    chk(lane_res(l) == exp_code, req, lane_res(l), exp_code);
  endtask

  task automatic proto_check();
    chk(addr_err == 0, "R2", addr_err, 0);
    chk(clr_err == 0, "R3", clr_err, 0);
    chk(first_err == 0, "R1", first_err, 0);
    chk(order_err == 0, "R9", order_err, 0);
    chk(hold_err == 0, "R11", hold_err, 0);
    addr_err = 0; clr_err = 0; first_err = 0; order_err = 0; hold_err = 0;
  endtask

  task automatic run_train(input logic [NL-1:0] sel, input bit extra_start);
    int d0, top;
    d0 = done_cnt; cur_sel = sel; prev_lane = -1; top = 0;
    for (int k = 0; k < NL; k++) if (sel[k]) top = k;
    @(negedge clk); lane_sel_i = sel; start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (2) @(negedge clk);
    chk(lane_res(top) == 1, "R9 running code", lane_res(top), 1);
    if (extra_start) begin
      lane_sel_i = '1; start_i = 1;
      @(negedge clk); start_i = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 done count", done_cnt - d0, 1);
  endtask

  task automatic t_reset();
    for (int l = 0; l < NL; l++) begin
      chk(lane_tap(l) == 0, "R1 reset tap", lane_tap(l), 0);
      chk(lane_res(l) == 0, "R1 reset code", lane_res(l), 0);
    end
    chk(!done_o && !rd_valid_o && !phy_fifo_rst_o, "R1 reset outputs",
        int'({done_o, rd_valid_o, phy_fifo_rst_o}), 0);
  endtask

  task automatic t_basic();
    win_lo = '{3, 0, 10, 5}; win_hi = '{12, 9, 20, 6}; bad_idx = '{-1, -1, -1, -1};
    inj_kind = 0; stall_en = 0;
    run_train(4'b1111, 0);
    for (int l = 0; l < NL; l++) verify_lane(l, "R5 R6 R7 basic");
    proto_check();
  endtask

  task automatic t_partial();
    int t0, t2, c0, c2;
    t0 = lane_tap(0); t2 = lane_tap(2); c0 = lane_res(0); c2 = lane_res(2);
    win_lo = '{1, 7, 1, 0}; win_hi = '{2, 18, 2, 2}; bad_idx = '{-1, 7, -1, 0};
    stall_en = 1;
    run_train(4'b1010, 0);
    verify_lane(1, "R5 partial scan");
    verify_lane(3, "R7 low window");
    chk(lane_tap(0) == t0 && lane_tap(2) == t2, "R9 unselected tap", lane_tap(0), t0);
    chk(lane_res(0) == c0 && lane_res(2) == c2, "R9 unselected code", lane_res(2), c2);
    proto_check();
    stall_en = 0;
  endtask

  task automatic t_flag();
    win_lo = '{4, 0, 2, 0}; win_hi = '{15, 0, 20, 0}; bad_idx = '{-1, -1, -1, -1};
    inj_kind = 2; inj_lane = 0; inj_tap = 4; inj_idx = 3;      // dummy flag, correct data
    run_train(4'b0001, 0);
    verify_lane(0, "R4 dummy flag");
    inj_kind = 1; inj_lane = 2; inj_tap = 9; inj_idx = 0;      // masked flag ends window
    run_train(4'b0100, 0);
    verify_lane(2, "R4 masked flag");
    inj_kind = 0;
    proto_check();
  endtask

  task automatic t_saturate();
    win_lo = '{40, 25, 30, 0}; win_hi = '{40, 31, 30, 0}; bad_idx = '{-1, -1, -1, -1};
    run_train(4'b0111, 0);
    verify_lane(0, "R8 no window");
    verify_lane(1, "R8 window to top");
    verify_lane(2, "R7 window at 30");
    proto_check();
  endtask

  task automatic t_busy_start();
    int t1, t3;
    t1 = lane_tap(1); t3 = lane_tap(3);
    win_lo = '{12, 0, 0, 0}; win_hi = '{16, 0, 0, 0};
    run_train(4'b0001, 1);
    verify_lane(0, "R10 restart ignored");
    chk(lane_tap(1) == t1 && lane_tap(3) == t3, "R10 busy start", lane_tap(3), t3);
    proto_check();
  endtask

  task automatic t_zero_sel();
    int d0, r0;
    d0 = done_cnt; r0 = req_cnt;
    @(negedge clk); lane_sel_i = '0; start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (30) @(negedge clk);
    chk(done_cnt == d0, "R10 empty mask done", done_cnt - d0, 0);
    chk(req_cnt == r0, "R10 empty mask reads", req_cnt - r0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_basic();
    t_partial();
    t_flag();
    t_saturate();
    t_busy_start();
    t_zero_sel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule